// File: doc/BRIEF.md
# Bit-Slip Word Aligner with Slip Count

This block sits just after a deserializer and runs on its recovered word clock. Each cycle it takes a raw 20-bit word (two 10-bit code groups). The word boundary of that raw stream lands on an arbitrary bit once clock recovery has locked. The aligner keeps the previous raw word and builds each output word from 20 consecutive bits of the two-word history, starting at a selectable offset. It searches for the K28.5 comma by moving that offset one bit at a time. After each move it waits a fixed settling interval and then tests the first-received code group for a comma.

When the comma sits in the first code-group position, the aligner freezes the offset, raises its valid flag and from then on delivers aligned words. The frozen offset is reported as the slip count. Each step of that count is one unit interval: 320 ps at 3.125 Gb/s. Link-delay measurement firmware combines this fine value with a coarse word-clock delay. A resynchronize request discards the lock and starts the search again from offset zero. The block uses the resulting change in slip count to follow changes in the arrival phase.

Top module: `bsa_aligner`

## Requirements
- R1: While reset is active, aligned_valid is 0, slip_count is 0 and aligned_word is all zeros.
- R2: Bit 0 of every word is the first-received bit. aligned_word equals 20 consecutive bits of the stream formed by the previous raw word (earlier bits) followed by the current raw word. The selection starts slip_count bits into the previous word. The output is registered one clock after the raw word is presented.
- R3: slip_count stays within 0 to 19. Each search step raises it by exactly one, and a step from 19 goes to 0, so a stream without a comma keeps the search cycling.
- R4: A comma is recognised when the first-received code group (aligned bits 9:0) equals 10'h17C or 10'h283, which is K28.5 in negative and positive running disparity.
- R5: The first test happens on the first clock after reset or resynchronize. Each step is followed by 4 clocks with no test, so lock at slip s is declared on clock 1+5·s counted from the resynchronize clock.
- R6: Once locked, aligned_valid stays 1 and slip_count stays constant whatever the raw data does, until a resynchronize or reset. The first valid word carries the comma in its first code group.
- R7: A resynchronize request drops aligned_valid and returns slip_count to 0 on the next clock, and the search then restarts.
- R8: A comma found only in the second code-group position (bits 19:10) does not lock; the search steps past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Drop alignment and restart the comma search |
| raw_word | input | 20 | Unaligned word from the deserializer, bit 0 received first |
| aligned_word | output | 20 | Word taken at the current bit offset |
| aligned_valid | output | 1 | Comma alignment found and held |
| slip_count | output | 5 | Bit offset in use, 0 to 19 |

## Verification
Aligned words come out one clock after the raw word. Lock is due exactly 1+5·s clocks after the resynchronize clock. The bench counts clocks from the resynchronize edge and compares that count with the slip it expects. The expected slip is derived from the stream phase it drives. Each expected lock is queued before the resynchronize pulse. A monitor that samples on the falling clock edge pops the entry when the valid flag rises, so every comparison lands in the cycle the result is due. Each result is checked against its queued values: slip, latency, comma position and the alternating code-group pairs. Held state under changing data and the wrap of the search count are checked cycle by cycle.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  // code-group width; a word carries WORD_W / SYM_W groups
  localparam int SYM_W = 10;

  // K28.5 stored with bit 0 = first-received bit
  localparam logic [SYM_W-1:0] K_RDN = 10'h17C;  // 0011111010 on the wire
  localparam logic [SYM_W-1:0] K_RDP = 10'h283;  // 1100000101 on the wire

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_LOCK   = 2'd2
  } bsa_state_e;

  // comma recogniser, either running disparity
  function automatic logic is_comma(logic [SYM_W-1:0] sym);
    return (sym == K_RDN) || (sym == K_RDP);
  endfunction

  // next search offset, wrapping at span
  function automatic int unsigned slip_next(int unsigned cur, int unsigned span);
    return (cur + 1 >= span) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/bsa_history.sv
module bsa_history #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] raw_word,
  output logic [WORD_W-1:0] prev_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_word <= '0;
    else        prev_word <= raw_word;
  end

endmodule

// File: rtl/bsa_shifter.sv
module bsa_shifter #(
  parameter int WORD_W = 20,
  parameter int SLIP_W = 5
) (
  input  logic [WORD_W-1:0] cur_word,
  input  logic [WORD_W-1:0] prev_word,
  input  logic [SLIP_W-1:0] slip,
  output logic [WORD_W-1:0] window
);

  localparam int CAT_W = 2 * WORD_W;

  // older word in the low half: the stream reads upward from bit 0
  logic [CAT_W-1:0] history;
  assign history = {cur_word, prev_word};

  // one selector per output bit
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    logic [WORD_W-1:0] taps;
    for (genvar k = 0; k < WORD_W; k++) begin : g_tap
      assign taps[k] = history[i + k];
    end
    assign window[i] = (int'(slip) < WORD_W) ? taps[slip] : 1'b0;
  end

endmodule

// File: rtl/bsa_comma_det.sv
module bsa_comma_det (
  input  logic [bsa_pkg::SYM_W-1:0] sym,
  output logic                      hit
);

  import bsa_pkg::*;

  logic [1:0] match;
  assign match[0] = (sym == K_RDN);
  assign match[1] = (sym == K_RDP);
  assign hit = |match;

endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl #(
  parameter int WORD_W = 20,
  parameter int SLIP_W = 5,
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resync,
  input  logic              hit,
  output logic [SLIP_W-1:0] slip,
  output logic              locked,
  output logic              step_evt,
  output logic              hit_evt
);

  import bsa_pkg::*;

  localparam int CNT_W = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);

  bsa_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic             probe;

  // a comma test happens only in the hunt state and never alongside resync
  assign probe    = (st == ST_HUNT) && !resync;
  assign hit_evt  = probe && hit;
  assign step_evt = probe && !hit;
  assign locked   = (st == ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_HUNT;
      slip <= '0;
      cnt  <= '0;
    end else if (resync) begin
      st   <= ST_HUNT;
      slip <= '0;
      cnt  <= '0;
    end else begin
      case (st)
        ST_HUNT: begin
          if (hit) begin
            st <= ST_LOCK;
          end else begin
            slip <= SLIP_W'(slip_next(32'(slip), WORD_W));
            cnt  <= CNT_W'(SETTLE);
            st   <= (SETTLE == 0) ? ST_HUNT : ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          cnt <= cnt - 1'b1;
          if (cnt <= CNT_W'(1)) st <= ST_HUNT;
        end
        ST_LOCK: st <= ST_LOCK;
        default: st <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/bsa_aligner.sv
module bsa_aligner #(
  parameter int WORD_W = 20,
  parameter int SETTLE = 4,
  localparam int SLIP_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resync,
  input  logic [WORD_W-1:0] raw_word,
  output logic [WORD_W-1:0] aligned_word,
  output logic              aligned_valid,
  output logic [SLIP_W-1:0] slip_count
);

  import bsa_pkg::*;

  logic [WORD_W-1:0] prev_word;
  logic [WORD_W-1:0] window;
  logic [SLIP_W-1:0] slip;
  logic              hit;
  logic              locked;
  logic              step_evt;
  logic              hit_evt;

  bsa_history #(.WORD_W(WORD_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_word (raw_word),
    .prev_word(prev_word)
  );

  bsa_shifter #(.WORD_W(WORD_W), .SLIP_W(SLIP_W)) u_shift (
    .cur_word (raw_word),
    .prev_word(prev_word),
    .slip     (slip),
    .window   (window)
  );

  // only the first-received code group may declare alignment
  bsa_comma_det u_det (
    .sym(window[SYM_W-1:0]),
    .hit(hit)
  );

  bsa_ctrl #(.WORD_W(WORD_W), .SLIP_W(SLIP_W), .SETTLE(SETTLE)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .resync  (resync),
    .hit     (hit),
    .slip    (slip),
    .locked  (locked),
    .step_evt(step_evt),
    .hit_evt (hit_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aligned_word <= '0;
    else        aligned_word <= window;
  end

  assign aligned_valid = locked;
  assign slip_count    = slip;

endmodule

// File: rtl/bsa_aligner_chk.sv
module bsa_aligner_chk #(
  parameter int WORD_W = 20,
  parameter int SETTLE = 4,
  localparam int SLIP_W = $clog2(WORD_W)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      resync,
  input logic [bsa_pkg::SYM_W-1:0] first_sym,
  input logic                      aligned_valid,
  input logic [SLIP_W-1:0]         slip_count,
  input logic                      step_evt,
  input logic                      hit_evt
);

  import bsa_pkg::*;

  localparam int GAP_W = $clog2(SETTLE + 2);
  localparam logic [SLIP_W-1:0] MAXS = SLIP_W'(WORD_W - 1);

  // clocks since the last step, saturating at SETTLE
  logic [GAP_W-1:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gap <= GAP_W'(SETTLE);
    else if (resync)                 gap <= GAP_W'(SETTLE);
    else if (step_evt)               gap <= '0;
    else if (gap < GAP_W'(SETTLE))   gap <= gap + 1'b1;
  end

  p_slip_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slip_count <= MAXS);

  p_step_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> slip_count == (($past(slip_count) == MAXS) ? '0 : $past(slip_count) + 1'b1));

  p_settle_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> gap >= GAP_W'(SETTLE));

  p_slip_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !resync) |=> $stable(slip_count));

  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned_valid && !resync) |=> aligned_valid);

  p_lock_comma_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned_valid) |-> is_comma(first_sym));

  p_lock_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned_valid) |-> $past(hit_evt));

  p_resync_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (!aligned_valid && slip_count == '0));

endmodule

bind bsa_aligner bsa_aligner_chk #(.WORD_W(WORD_W), .SETTLE(SETTLE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .resync       (resync),
  .first_sym    (aligned_word[bsa_pkg::SYM_W-1:0]),
  .aligned_valid(aligned_valid),
  .slip_count   (slip_count),
  .step_evt     (step_evt),
  .hit_evt      (hit_evt)
);

// File: tb/bsa_aligner_bench.sv
module bsa_aligner_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        resync = 1'b0;
  logic [19:0] raw_word = '0;
  logic [19:0] aligned_word;
  logic        aligned_valid;
  logic [4:0]  slip_count;

  bsa_aligner u_bsa_aligner (
    .clk          (clk),
    .rst_n        (rst_n),
    .resync       (resync),
    .raw_word     (raw_word),
    .aligned_word (aligned_word),
    .aligned_valid(aligned_valid),
    .slip_count   (slip_count)
  );

  always #10 clk = ~clk;  // 50 MHz

  // 40-bit repeating line pattern, bit index = transmit order:
  // comma(-), filler, comma(+), filler; every 5-bit run lies inside a comma
  localparam logic [39:0] PAT_K = {10'h155, 10'h283, 10'h2AA, 10'h17C};
  localparam logic [39:0] PAT_N = {4{10'h2AA}};
  localparam logic [19:0] HALF0 = PAT_K[19:0];
  localparam logic [19:0] HALF1 = PAT_K[39:20];

  int          phase = 1;
  bit          use_k = 1'b1;
  int unsigned widx = 0;
  int          cyc = 0;
  int          vecs = 0;
  int          errs = 0;
  bit          done = 1'b0;

  function automatic logic [19:0] make_word(bit k, int ph, int unsigned n);
    logic [19:0] w;
    for (int i = 0; i < 20; i++) begin
      w[i] = k ? PAT_K[(20 * n + ph + i) % 40] : PAT_N[(20 * n + ph + i) % 40];
    end
    return w;
  endfunction

  always @(negedge clk) begin
    raw_word <= make_word(use_k, phase, widx);
    widx     <= widx + 1;
  end

  // clocks since the resync edge
  always @(posedge clk) begin
    if (resync) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { int slip; int lat; } exp_t;
  exp_t        sb[$];
  exp_t        cur_e;
  logic        prev_v = 1'b0;
  logic [19:0] last_w = '0;
  bit          chk_words = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (aligned_valid && !prev_v) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6", "unexpected lock", 1, 0);
        end else begin
          cur_e = sb.pop_front();
          check(slip_count == cur_e.slip, "R3", "slip count at lock", slip_count, cur_e.slip);
          check(cyc == cur_e.lat, "R5 R8", "lock latency", cyc, cur_e.lat);
          check(aligned_word[9:0] == 10'h17C || aligned_word[9:0] == 10'h283,
                "R4", "first group is comma", aligned_word[9:0], 10'h17C);
          check(aligned_word == HALF0 || aligned_word == HALF1,
                "R2", "first aligned word", aligned_word, HALF0);
        end
      end else if (aligned_valid && prev_v && chk_words) begin
        check(aligned_word != last_w && (aligned_word == HALF0 || aligned_word == HALF1),
              "R2", "aligned word alternation", aligned_word,
              (last_w == HALF0) ? HALF1 : HALF0);
      end
    end
    prev_v <= aligned_valid;
    last_w <= aligned_word;
  end

  task automatic pulse_resync();
    @(negedge clk);
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    check(!aligned_valid && slip_count == 0, "R7", "cleared by resync",
          {aligned_valid, slip_count}, 0);
  endtask

  task automatic lock_at(int ph);
    int s;
    s = (20 - (ph % 20)) % 20;
    phase = ph;
    @(negedge clk);
    sb.push_back('{slip: s, lat: 1 + 5 * s});
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    check(!aligned_valid && slip_count == 0, "R7", "cleared by resync",
          {aligned_valid, slip_count}, 0);
    for (int i = 0; i < 150 && sb.size() != 0; i++) @(negedge clk);
    check(sb.size() == 0, "R5", "lock reached", sb.size(), 0);
    chk_words = 1'b1;
    repeat (10) @(negedge clk);
    chk_words = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!aligned_valid && slip_count == 0 && aligned_word == 0, "R1", "reset state",
          {aligned_valid, slip_count, aligned_word}, 0);
    rst_n = 1'b1;

    lock_at(0);
    lock_at(1);
    lock_at(7);

    // R6: locked state ignores a new phase in the raw data
    phase = 3;
    repeat (30) begin
      @(negedge clk);
      check(aligned_valid && slip_count == 13, "R6", "held while locked",
            {aligned_valid, slip_count}, {1'b1, 5'd13});
    end

    lock_at(25);
    lock_at(30);  // R8: passes slip 0 with comma in upper group
    lock_at(39);
    lock_at(12);

    // R3: no comma in the stream, the search keeps cycling and wraps
    begin
      bit saw_wrap;
      int last_s;
      int max_s;
      saw_wrap = 1'b0;
      last_s = 0;
      max_s = 0;
      use_k = 1'b0;
      pulse_resync();
      repeat (130) begin
        @(negedge clk);
        if (last_s == 19 && slip_count == 0) saw_wrap = 1'b1;
        if (slip_count > max_s) max_s = slip_count;
        if (aligned_valid) check(1'b0, "R3", "lock without comma", 1, 0);
        last_s = slip_count;
      end
      check(saw_wrap, "R3", "slip wrap 19 to 0", saw_wrap, 1);
      check(max_s == 19, "R3", "highest slip", max_s, 19);
      use_k = 1'b1;
    end
    lock_at(5);

    // R1: reset in mid-run
    phase = 1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!aligned_valid && slip_count == 0 && aligned_word == 0, "R1", "reset mid-run",
          {aligned_valid, slip_count, aligned_word}, 0);
    rst_n = 1'b1;
    lock_at(10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule